// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Chain with Lock Monitor

This block holds the digital counters of an integer-N frequency synthesizer. One counter divides reference-clock events down to the phase-comparison rate. A second counter, built as a dual-modulus swallow scheme, divides oscillator-side events by a programmable ratio N = 32·M + S. A digital lock monitor compares the two divided pulse trains period by period. A test selector routes either the lock status or one of several divided clocks to a single monitor pin, and also drives a flag that puts the charge pump into high impedance.

Both input clocks are modelled as one-cycle event pulses (`ref_pulse`, `vco_pulse`) sampled on a fast system clock `clk`. Divided outputs are one-cycle pulses, registered one cycle after the event that completes a period. The chain runs only while `pll_en` is high. Divider settings are latched at each terminal count, so a change made part-way through a period never shortens or stretches that period.

State machines: the swallow counter has the states PS_SWALLOW (prescaler modulus 33) and PS_MAIN (modulus 32). PS_SWALLOW moves to PS_MAIN after S prescaler cycles. Terminal count moves to PS_SWALLOW, or to PS_MAIN when the new S is 0. Disable reloads the same way. The lock monitor has the states LD_IDLE, LD_WAIT_PC and LD_WAIT_RC. LD_IDLE scores a hit when both pulses arrive together. It moves to LD_WAIT_PC on a lone reference pulse and to LD_WAIT_RC on a lone divided pulse. Each wait state returns to LD_IDLE on the next cycle, with a hit if the partner pulse arrived and a miss if it did not. Disable forces LD_IDLE.

Top module: `synth_divider_chain`

## Requirements
- R1: `rc_out` pulses once every D sampled `ref_pulse` events, with D = 3, 4, 6, 8 for `ref_sel` = 0, 1, 2, 3. Each pulse is one cycle wide.
- R2: `pc_out` pulses once every N sampled `vco_pulse` events, where N = 32·(`main_sel` + 40) + `swal_sel`. This covers the full range, from N = 1280 (`main_sel`=0, `swal_sel`=0) to N = 1535 (`main_sel`=7, `swal_sel`=31).
- R3: A change of `ref_sel`, `main_sel` or `swal_sel` during a period leaves that period at its old length. The new value governs every period from the next one on.
- R4: While `pll_en` is low, `rc_out`, `pc_out` and `lock_det` stay 0 and the divided test clocks are held at 0. On re-enable, counting restarts from zero.
- R5: `lock_det` goes to 1 one cycle after the 16th consecutive hit. It is still 0 after 15 hits.
- R6: A miss clears the hit count. `lock_det` is 0 from the cycle after the miss.
- R7: A hit is either `rc_out` and `pc_out` high in the same cycle, or one of them high in the cycle right after the other. A gap of two cycles is a miss.
- R8: `test_sel[1:0]` selects the source of `mon_out`. The value 0 gives lock status, 1 gives PC/2 and 2 gives RC/2. The value 3 gives RC/512 when `test_sel[2]`=0 and raw `rc_out` when `test_sel[2]`=1. `cp_hiz` equals `test_sel[2]`.
- R9: PC/2 and RC/2 start at 0 on enable and toggle one cycle after each `pc_out` / `rc_out` pulse. RC/512 is 1 from the 256th `rc_out` pulse through the 511th, then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Runs the divider chain when high |
| ref_pulse | input | 1 | One-cycle reference clock event |
| vco_pulse | input | 1 | One-cycle oscillator clock event |
| ref_sel | input | 2 | Reference ratio code (3/4/6/8) |
| main_sel | input | 3 | Main count code, M = code + 40 |
| swal_sel | input | 5 | Swallow count S, 0..31 |
| test_sel | input | 3 | Monitor source and charge-pump high-impedance select |
| rc_out | output | 1 | Divided reference pulse |
| pc_out | output | 1 | Divided oscillator pulse |
| lock_det | output | 1 | Lock status, 1 when locked |
| mon_out | output | 1 | Selected monitor signal |
| cp_hiz | output | 1 | Charge pump high-impedance request |

## Verification
The bench measures pulse spacing on both outputs at the extremes of the swallow range. It also changes the ratios part-way through a period: a design that reloads at once instead of at terminal count gives a shortened period in progress. The lock count is probed two cycles before and after the 16th hit, which exposes an off-by-one threshold. Reference pulses delayed by one and then two cycles separate a correct capture window from one that is too narrow or too wide. A late reference pulse after lock must drop the status, which catches a monitor that only ever sets it. The RC/512 output is probed either side of its 256th pulse, and the raw-reference mode is selected through the high-impedance code group, so a decoder that ignores the top bit shows up.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [1:0] {
        LD_IDLE    = 2'd0,
        LD_WAIT_PC = 2'd1,
        LD_WAIT_RC = 2'd2
    } ld_state_t;

    typedef enum logic {
        PS_SWALLOW = 1'b0,
        PS_MAIN    = 1'b1
    } ps_state_t;

    typedef enum logic [1:0] {
        SRC_LOCK    = 2'd0,
        SRC_PC_HALF = 2'd1,
        SRC_RC_HALF = 2'd2,
        SRC_RC_SLOW = 2'd3
    } mon_src_t;

    localparam int REF_SEL_W  = 2;
    localparam int TEST_SEL_W = 3;

    // reference ratio for each selection code
    function automatic int unsigned ref_ratio(input logic [REF_SEL_W-1:0] code);
        int unsigned r;
        unique case (code)
            2'd0:    r = 3;
            2'd1:    r = 4;
            2'd2:    r = 6;
            default: r = 8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
    import synth_div_pkg::*;
#(
    parameter int MAX_RATIO = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pll_en,
    input  logic                 ref_pulse,
    input  logic [REF_SEL_W-1:0] ref_sel,
    output logic                 rc_tc
);
    localparam int CNT_W = $clog2(MAX_RATIO);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] last_new;
    logic             wrap;
    logic             tc_q;

    assign last_new = CNT_W'(ref_ratio(ref_sel) - 1);
    assign wrap     = ref_pulse && (cnt_q == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= CNT_W'(ref_ratio('0) - 1);
            tc_q   <= 1'b0;
        end else if (!pll_en) begin
            cnt_q  <= '0;
            last_q <= last_new;
            tc_q   <= 1'b0;
        end else begin
            tc_q <= wrap;
            if (ref_pulse) begin
                if (wrap) begin
                    cnt_q  <= '0;
                    last_q <= last_new;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign rc_tc = tc_q;

    // R1
    rc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |=> !tc_q);

    // R4
    rc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> (!tc_q && cnt_q == '0));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import synth_div_pkg::*;
#(
    parameter int MAIN_W    = 3,
    parameter int SWAL_W    = 5,
    parameter int PRESCALE  = 32,
    parameter int MAIN_BASE = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_en,
    input  logic              vco_pulse,
    input  logic [MAIN_W-1:0] main_sel,
    input  logic [SWAL_W-1:0] swal_sel,
    output logic              pc_tc
);
    localparam int PRE_W  = $clog2(PRESCALE + 1);
    localparam int MCNT_W = $clog2(MAIN_BASE + (1 << MAIN_W));

    ps_state_t         state_q, state_d;
    logic [MCNT_W-1:0] m_q;
    logic [SWAL_W-1:0] s_q;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [MCNT_W-1:0] main_cnt_q;
    logic [SWAL_W-1:0] swal_cnt_q;
    logic [PRE_W-1:0]  pre_last;
    logic [MCNT_W-1:0] m_new;
    logic              pre_wrap;
    logic              main_wrap;
    logic              swal_done;
    logic              tc_q;

    assign m_new     = MCNT_W'(MAIN_BASE) + MCNT_W'(main_sel);
    assign pre_last  = (state_q == PS_SWALLOW) ? PRE_W'(PRESCALE) : PRE_W'(PRESCALE - 1);
    assign pre_wrap  = vco_pulse && (pre_cnt_q == pre_last);
    assign main_wrap = pre_wrap && (main_cnt_q == m_q - MCNT_W'(1));
    assign swal_done = pre_wrap && (state_q == PS_SWALLOW) && (swal_cnt_q == s_q - SWAL_W'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_SWALLOW: begin
                if (main_wrap)      state_d = (swal_sel == '0) ? PS_MAIN : PS_SWALLOW;
                else if (swal_done) state_d = PS_MAIN;
            end
            PS_MAIN: begin
                if (main_wrap)      state_d = (swal_sel == '0) ? PS_MAIN : PS_SWALLOW;
            end
            default:                state_d = PS_MAIN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= PS_MAIN;
        else if (!pll_en) state_q <= (swal_sel == '0) ? PS_MAIN : PS_SWALLOW;
        else              state_q <= state_d;
    end

    // counters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q        <= MCNT_W'(MAIN_BASE);
            s_q        <= '0;
            pre_cnt_q  <= '0;
            main_cnt_q <= '0;
            swal_cnt_q <= '0;
            tc_q       <= 1'b0;
        end else if (!pll_en) begin
            m_q        <= m_new;
            s_q        <= swal_sel;
            pre_cnt_q  <= '0;
            main_cnt_q <= '0;
            swal_cnt_q <= '0;
            tc_q       <= 1'b0;
        end else begin
            tc_q <= main_wrap;
            if (vco_pulse) pre_cnt_q <= pre_wrap ? '0 : pre_cnt_q + 1'b1;
            if (main_wrap) begin
                main_cnt_q <= '0;
                swal_cnt_q <= '0;
                m_q        <= m_new;
                s_q        <= swal_sel;
            end else if (pre_wrap) begin
                main_cnt_q <= main_cnt_q + 1'b1;
                if (state_q == PS_SWALLOW) swal_cnt_q <= swal_cnt_q + 1'b1;
            end
        end
    end

    assign pc_tc = tc_q;

    // R2
    swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SWALLOW) |-> (swal_cnt_q < s_q));

    // R2
    main_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_cnt_q < m_q);

    // R2
    pc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |=> !tc_q);

endmodule

// File: rtl/lock_detector.sv
module lock_detector
    import synth_div_pkg::*;
#(
    parameter int LOCK_PERIODS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic rc_tc,
    input  logic pc_tc,
    output logic locked
);
    localparam int CNT_W = $clog2(LOCK_PERIODS + 1);

    ld_state_t        st_q, st_d;
    logic             hit;
    logic             miss;
    logic [CNT_W-1:0] run_q;

    // next state, hit and miss
    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        miss = 1'b0;
        unique case (st_q)
            LD_IDLE: begin
                if (rc_tc && pc_tc) hit = 1'b1;
                else if (rc_tc)     st_d = LD_WAIT_PC;
                else if (pc_tc)     st_d = LD_WAIT_RC;
            end
            LD_WAIT_PC: begin
                st_d = LD_IDLE;
                if (pc_tc) hit  = 1'b1;
                else       miss = 1'b1;
            end
            LD_WAIT_RC: begin
                st_d = LD_IDLE;
                if (rc_tc) hit  = 1'b1;
                else       miss = 1'b1;
            end
            default: st_d = LD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st_q <= LD_IDLE;
        else if (!pll_en) st_q <= LD_IDLE;
        else              st_q <= st_d;
    end

    // consecutive hit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         run_q <= '0;
        else if (!pll_en || miss)                           run_q <= '0;
        else if (hit && run_q != CNT_W'(LOCK_PERIODS))      run_q <= run_q + 1'b1;
    end

    // output
    always_comb locked = (run_q == CNT_W'(LOCK_PERIODS));

    // R6
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !locked);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(hit));

    // R4
    lock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> !locked);

endmodule

// File: rtl/monitor_select.sv
module monitor_select
    import synth_div_pkg::*;
#(
    parameter int SLOW_DIV = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pll_en,
    input  logic                  rc_tc,
    input  logic                  pc_tc,
    input  logic                  locked,
    input  logic [TEST_SEL_W-1:0] test_sel,
    output logic                  mon_out,
    output logic                  cp_hiz
);
    localparam int SLOW_W = $clog2(SLOW_DIV);

    logic              pc_half_q;
    logic              rc_half_q;
    logic [SLOW_W-1:0] slow_q;
    mon_src_t          src;
    logic              hiz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_half_q <= 1'b0;
            rc_half_q <= 1'b0;
            slow_q    <= '0;
        end else if (!pll_en) begin
            pc_half_q <= 1'b0;
            rc_half_q <= 1'b0;
            slow_q    <= '0;
        end else begin
            if (pc_tc) pc_half_q <= ~pc_half_q;
            if (rc_tc) begin
                rc_half_q <= ~rc_half_q;
                slow_q    <= slow_q + 1'b1;
            end
        end
    end

    assign src = mon_src_t'(test_sel[1:0]);
    assign hiz = test_sel[2];

    always_comb begin
        unique case (src)
            SRC_LOCK:    mon_out = locked;
            SRC_PC_HALF: mon_out = pc_half_q;
            SRC_RC_HALF: mon_out = rc_half_q;
            SRC_RC_SLOW: mon_out = hiz ? rc_tc : slow_q[SLOW_W-1];
            default:     mon_out = 1'b0;
        endcase
    end

    assign cp_hiz = hiz;

    // R4
    mon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> (!pc_half_q && !rc_half_q && slow_q == '0));

endmodule

// File: rtl/synth_divider_chain.sv
module synth_divider_chain
    import synth_div_pkg::*;
#(
    parameter int MAIN_W       = 3,
    parameter int SWAL_W       = 5,
    parameter int PRESCALE     = 32,
    parameter int MAIN_BASE    = 40,
    parameter int LOCK_PERIODS = 16,
    parameter int SLOW_DIV     = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pll_en,
    input  logic                  ref_pulse,
    input  logic                  vco_pulse,
    input  logic [REF_SEL_W-1:0]  ref_sel,
    input  logic [MAIN_W-1:0]     main_sel,
    input  logic [SWAL_W-1:0]     swal_sel,
    input  logic [TEST_SEL_W-1:0] test_sel,
    output logic                  rc_out,
    output logic                  pc_out,
    output logic                  lock_det,
    output logic                  mon_out,
    output logic                  cp_hiz
);
    logic rc_tc;
    logic pc_tc;
    logic locked;

    ref_divider #(.MAX_RATIO(8)) u_ref (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .ref_pulse(ref_pulse), .ref_sel(ref_sel), .rc_tc(rc_tc)
    );

    swallow_divider #(
        .MAIN_W(MAIN_W), .SWAL_W(SWAL_W),
        .PRESCALE(PRESCALE), .MAIN_BASE(MAIN_BASE)
    ) u_swal (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .vco_pulse(vco_pulse), .main_sel(main_sel), .swal_sel(swal_sel),
        .pc_tc(pc_tc)
    );

    lock_detector #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .rc_tc(rc_tc), .pc_tc(pc_tc), .locked(locked)
    );

    monitor_select #(.SLOW_DIV(SLOW_DIV)) u_mon (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .rc_tc(rc_tc), .pc_tc(pc_tc), .locked(locked),
        .test_sel(test_sel), .mon_out(mon_out), .cp_hiz(cp_hiz)
    );

    assign rc_out   = rc_tc;
    assign pc_out   = pc_tc;
    assign lock_det = locked;

endmodule

// File: tb/test_synth_divider_chain.sv
module test_synth_divider_chain;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pll_en;
    logic       vco_pulse;
    logic [1:0] ref_sel;
    logic [2:0] main_sel;
    logic [4:0] swal_sel;
    logic [2:0] test_sel;
    logic       rc_out, pc_out, lock_det, mon_out, cp_hiz;
    logic       ref_pulse;

    logic gen_on;
    int   sp;
    int   dly;
    int   ph;
    int   checks = 0;
    int   fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference event generator: one pulse every sp cycles, start delayed by dly
    always @(posedge clk) begin
        if (!gen_on) ph <= -dly;
        else         ph <= (ph >= sp - 1) ? 0 : ph + 1;
    end
    assign ref_pulse = gen_on && (ph == sp - 1);

    synth_divider_chain i_synth_divider_chain (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .ref_sel(ref_sel), .main_sel(main_sel), .swal_sel(swal_sel),
        .test_sel(test_sel),
        .rc_out(rc_out), .pc_out(pc_out), .lock_det(lock_det),
        .mon_out(mon_out), .cp_hiz(cp_hiz)
    );

    localparam int NV = 4;
    localparam int V_RS [NV] = '{0, 1, 2, 3};
    localparam int V_MS [NV] = '{0, 7, 3, 5};
    localparam int V_SS [NV] = '{0, 31, 5, 17};
    localparam int V_SP [NV] = '{1, 2, 5, 3};

    function automatic int ratio_of(input int code);
        case (code)
            0: return 3;
            1: return 4;
            2: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int n_of(input int ms, input int ss);
        return 32 * (ms + 40) + ss;
    endfunction

    task automatic check_eq(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_run();
        @(negedge clk);
        pll_en = 1'b1;
        gen_on = 1'b1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        pll_en = 1'b0;
        gen_on = 1'b0;
        tick(2);
    endtask

    function automatic logic sig_of(input bit use_pc);
        return use_pc ? pc_out : rc_out;
    endfunction

    task automatic wait_high(input bit use_pc);
        int g = 0;
        tick(1);
        while (sig_of(use_pc) == 1'b0 && g < 5000) begin
            tick(1);
            g++;
        end
    endtask

    task automatic gap_to_next(input bit use_pc, output int gap);
        tick(1);
        gap = 1;
        while (sig_of(use_pc) == 1'b0 && gap < 5000) begin
            tick(1);
            gap++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int gap;
        int n;
        rst_n = 1'b0; pll_en = 1'b0; gen_on = 1'b0; vco_pulse = 1'b1;
        sp = 1; dly = 0;
        ref_sel = 2'd0; main_sel = 3'd0; swal_sel = 5'd0; test_sel = 3'd0;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // reset state
        check_eq("R4 reset rc_out", rc_out, 0);
        check_eq("R4 reset pc_out", pc_out, 0);
        check_eq("R4 reset lock_det", lock_det, 0);
        check_eq("R8 reset mon_out", mon_out, 0);
        check_eq("R8 reset cp_hiz", cp_hiz, 0);

        // vector table: R1 ratios and R2 swallow division
        for (int v = 0; v < NV; v++) begin
            ref_sel = V_RS[v][1:0]; main_sel = V_MS[v][2:0]; swal_sel = V_SS[v][4:0]; sp = V_SP[v];
            start_run();
            wait_high(1'b0);
            gap_to_next(1'b0, gap);
            check_eq($sformatf("R1 rc period vec %0d", v), gap, ratio_of(V_RS[v]) * V_SP[v]);
            wait_high(1'b1);
            gap_to_next(1'b1, gap);
            check_eq($sformatf("R2 pc period vec %0d", v), gap, n_of(V_MS[v], V_SS[v]));
            stop_run();
        end

        // R3: settings change mid-period
        ref_sel = 2'd0; main_sel = 3'd0; swal_sel = 5'd0; sp = 10;
        start_run();
        wait_high(1'b0);
        tick(5);
        ref_sel = 2'd3;
        gap_to_next(1'b0, gap);
        check_eq("R3 rc period in progress keeps old ratio", gap + 5, 30);
        gap_to_next(1'b0, gap);
        check_eq("R3 rc next period uses new ratio", gap, 80);
        wait_high(1'b1);
        tick(100);
        main_sel = 3'd7; swal_sel = 5'd31;
        gap_to_next(1'b1, gap);
        check_eq("R3 pc period in progress keeps old N", gap + 100, 1280);
        gap_to_next(1'b1, gap);
        check_eq("R3 pc next period uses new N", gap, 1535);
        stop_run();

        // R9 / R8: divided test clocks
        ref_sel = 2'd0; main_sel = 3'd0; swal_sel = 5'd0; sp = 1; test_sel = 3'b010;
        start_run();
        tick(5);
        check_eq("R9 rc/2 high after first rc pulse", mon_out, 1);
        tick(3);
        check_eq("R9 rc/2 low after second rc pulse", mon_out, 0);
        test_sel = 3'b011;
        tick(766 - 8);
        check_eq("R9 rc/512 low before 256th pulse", mon_out, 0);
        check_eq("R8 cp_hiz low for code 011", cp_hiz, 0);
        tick(4);
        check_eq("R9 rc/512 high after 256th pulse", mon_out, 1);
        test_sel = 3'b111;
        tick(1);
        check_eq("R8 raw rc on code 111 during pulse", mon_out, 1);
        check_eq("R8 cp_hiz high for code 111", cp_hiz, 1);
        tick(1);
        check_eq("R8 raw rc on code 111 between pulses", mon_out, 0);
        test_sel = 3'b101;
        tick(1278 - 772);
        check_eq("R9 pc/2 low before first pc pulse", mon_out, 0);
        tick(4);
        check_eq("R9 pc/2 high after first pc pulse", mon_out, 1);
        stop_run();

        // R5: lock after 16 hits, D=4, N=1280
        ref_sel = 2'd1; main_sel = 3'd0; swal_sel = 5'd0; sp = 320; dly = 0; test_sel = 3'b000;
        n = 1280;
        start_run();
        tick(16 * n - 3);
        check_eq("R5 no lock after 15 hits", lock_det, 0);
        check_eq("R8 mon_out follows lock (unlocked)", mon_out, 0);
        tick(6);
        check_eq("R5 lock after 16 hits", lock_det, 1);
        check_eq("R8 mon_out follows lock (locked)", mon_out, 1);
        test_sel = 3'b100;
        tick(1);
        check_eq("R8 code 100 gives lock", mon_out, 1);
        check_eq("R8 code 100 sets cp_hiz", cp_hiz, 1);

        // R6: late reference clears lock
        wait_high(1'b1);
        sp = 321;
        tick(1275);
        check_eq("R6 lock held before miss", lock_det, 1);
        tick(15);
        check_eq("R6 lock cleared by miss", lock_det, 0);

        // R4: disable with reference still running
        test_sel = 3'b010;
        @(negedge clk);
        pll_en = 1'b0;
        sp = 320;
        tick(2);
        n = 0;
        for (int i = 0; i < 1500; i++) begin
            tick(1);
            if (rc_out || pc_out) n++;
        end
        check_eq("R4 no divided pulses while disabled", n, 0);
        check_eq("R4 lock low while disabled", lock_det, 0);
        check_eq("R4 rc/2 held low while disabled", mon_out, 0);
        stop_run();

        // R7: one-cycle skew is a hit, two-cycle skew is a miss
        test_sel = 3'b000; sp = 320; dly = 1;
        n = 1280;
        start_run();
        tick(16 * n + 5);
        check_eq("R7 lock with reference one cycle late", lock_det, 1);
        stop_run();
        dly = 2;
        start_run();
        tick(16 * n + 5);
        check_eq("R7 no lock with reference two cycles late", lock_det, 0);
        stop_run();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule